// File: doc/BRIEF.md
# PC Reuse Predictor Table

This block is a small fully associative table that learns, for each program counter, whether the cache lines that the program counter brings into a sampled group of cache sets are used again before they leave the cache. Each entry holds a tag, a 6-bit confidence counter and a count of the sampled lines that still point at it. The tag is the program counter combined with the cache's current default insertion policy, so one program counter keeps two separate histories.

The surrounding cache controller drives three kinds of event into the block. The first is a miss in a sampled set, which carries the program counter, the default policy and a fill flag. The second is a hit on a sampled line, which carries the entry index and reuse bit stored with that line. The third is an eviction of a sampled line, which carries the same two stored fields.

For a miss, the block answers in the same cycle. It reports whether the key is present, whether the owning entry currently advises bypass, and which entry index the controller must store with the filled line. That index is either the matching entry or a newly allocated one. All table updates are registered and take effect at the next clock edge.

Top module: `pcrt_table`

## Requirements
- R1: After reset every entry is free. A lookup reports no match and no bypass, and offers index 0 for allocation.
- R2: The lookup key is the pair {policy, PC}, where policy 0 means LRU and policy 1 means bypass. The same PC under the two policies occupies two distinct entries, and at most one entry matches any key.
- R3: A miss whose key is absent allocates the free entry with the lowest index, but only when the fill flag is 1. The new entry starts with counter 31 and one referencing line. A miss without fill changes nothing.
- R4: The bypass output is 1 exactly when the key matches and the matching entry's counter is 32 or more, which is the counter's top bit.
- R5: A hit whose stored reuse bit is 0 decrements the entry's counter, saturating at 0. A hit whose reuse bit is 1 leaves the counter unchanged.
- R6: An eviction whose stored reuse bit is 0 increments the entry's counter, saturating at 63. An eviction whose reuse bit is 1 leaves the counter unchanged.
- R7: A filled miss that matches an entry adds one to its line count. Every eviction subtracts one, whether or not the line was reused. At a count of zero the entry is free, stops matching, and can be allocated again with its counter reset to 31.
- R8: When no entry is free, a miss with an absent key reports no allocation and the table does not change.
- R9: A hit and an eviction on the same entry in the same cycle apply their net effect to the counter. For example, an unreused hit and an unreused eviction together leave the counter unchanged, and this holds at the saturation limits too.
- R10: A lookup sees the table state from before the updates of its own cycle. A key whose last line is evicted in that cycle still matches in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_vld | input | 1 | Miss in a sampled set this cycle |
| miss_pc | input | PC_W | Program counter of the missing access |
| miss_pol | input | 1 | Current default policy (0 LRU, 1 bypass) |
| miss_fill | input | 1 | The missing line is inserted into the sampled set |
| hit_vld | input | 1 | Hit on a sampled line this cycle |
| hit_idx | input | IDX_W | Entry index stored with the hit line |
| hit_reuse | input | 1 | Reuse bit stored with the hit line |
| evict_vld | input | 1 | Eviction of a sampled line this cycle |
| evict_idx | input | IDX_W | Entry index stored with the evicted line |
| evict_reuse | input | 1 | Reuse bit stored with the evicted line |
| look_match | output | 1 | Miss key is present in the table |
| look_bypass | output | 1 | Matching entry advises bypass |
| look_alloc | output | 1 | Key absent and a free entry is available |
| look_idx | output | IDX_W | Matching or allocatable entry index |

## Verification
Hits and evictions are independent ports, so both can strike the same entry in one cycle. The bench provokes this on the same entry while a filled miss matches it as well. It does so first with the counter pinned at 63 and then with the counter pinned at 0. A design that applies the hit and the eviction one after the other with saturation between them ends at a different counter value. That difference shows up when the bench later walks the counter across the bypass threshold. A second overlap, an eviction that releases an entry's last line while a lookup of that entry is in flight, is judged from the lookup outputs of that cycle and of the next one.

// File: rtl/pcrt_pkg.sv
package pcrt_pkg;
  localparam int CONF_W = 6;
  localparam int CONF_MAX = (1 << CONF_W) - 1;
  localparam int CONF_INIT = (1 << (CONF_W - 1)) - 1;

  typedef logic [CONF_W-1:0] conf_t;

  typedef enum logic {
    POL_LRU = 1'b0,
    POL_BYP = 1'b1
  } pol_e;

  // Net saturating step: up and down in the same cycle cancel.
  function automatic conf_t conf_step(conf_t c, logic up, logic dn);
    conf_t r;
    r = c;
    if (up && !dn && c != conf_t'(CONF_MAX)) r = c + conf_t'(1);
    if (dn && !up && c != conf_t'(0)) r = c - conf_t'(1);
    return r;
  endfunction

  function automatic logic conf_bypass(conf_t c);
    return c[CONF_W-1];
  endfunction
endpackage

// File: rtl/pcrt_entry.sv
module pcrt_entry #(
  parameter int KEY_W = 17,
  parameter int REF_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [KEY_W-1:0] key_i,
  input  logic             alloc_i,
  input  logic             fill_i,
  input  logic             up_i,
  input  logic             dn_i,
  input  logic             rel_i,
  output logic             hit_o,
  output logic             free_o,
  output logic             bypass_o
);
  import pcrt_pkg::*;

  logic [KEY_W-1:0] tag_q;
  conf_t            conf_q;
  logic [REF_W-1:0] ref_q;

  assign free_o   = (ref_q == '0);
  assign hit_o    = !free_o && (tag_q == key_i);
  assign bypass_o = conf_bypass(conf_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q  <= '0;
      conf_q <= conf_t'(CONF_INIT);
      ref_q  <= '0;
    end else if (alloc_i) begin
      tag_q  <= key_i;
      conf_q <= conf_t'(CONF_INIT);
      ref_q  <= REF_W'(1);
    end else begin
      conf_q <= conf_step(conf_q, up_i, dn_i);
      ref_q  <= ref_q + REF_W'(fill_i) - REF_W'(rel_i);
    end
  end

  AST_ALLOC_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |-> free_o); // R3
  AST_ALLOC_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |=> (!free_o && !bypass_o)); // R3
  AST_QUIET_CONF: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_i && !up_i && !dn_i) |=> $stable(conf_q)); // R5
  AST_REF_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_i && !rel_i) |-> (ref_q != '1)); // R7
  AST_REF_NO_UNDER: assert property (@(posedge clk) disable iff (!rst_n)
    rel_i |-> !free_o); // R7
endmodule

// File: rtl/pcrt_alloc.sv
module pcrt_alloc #(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] free_i,
  output logic               found_o,
  output logic [IDX_W-1:0]   idx_o
);
  assign found_o = |free_i;

  always_comb begin
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (free_i[i]) idx_o = IDX_W'(i);
    end
  end

  logic [ENTRIES-1:0] below_mask;
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) below_mask[i] = (IDX_W'(i) < idx_o);
  end

  AST_LOWEST_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    found_o |-> (free_i[idx_o] && ((free_i & below_mask) == '0))); // R3
endmodule

// File: rtl/pcrt_table.sv
module pcrt_table #(
  parameter int PC_W    = 16,
  parameter int ENTRIES = 8,
  parameter int REF_W   = 4,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int KEY_W  = PC_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_vld,
  input  logic [PC_W-1:0]  miss_pc,
  input  logic             miss_pol,
  input  logic             miss_fill,
  input  logic             hit_vld,
  input  logic [IDX_W-1:0] hit_idx,
  input  logic             hit_reuse,
  input  logic             evict_vld,
  input  logic [IDX_W-1:0] evict_idx,
  input  logic             evict_reuse,
  output logic             look_match,
  output logic             look_bypass,
  output logic             look_alloc,
  output logic [IDX_W-1:0] look_idx
);
  logic [KEY_W-1:0]   key;
  logic [ENTRIES-1:0] match_vec, free_vec, byp_vec;
  logic [ENTRIES-1:0] alloc_vec, fill_vec, up_vec, dn_vec, rel_vec;
  logic               any_match, free_found, do_alloc;
  logic [IDX_W-1:0]   match_idx, free_idx;

  assign key = {miss_pol, miss_pc};

  pcrt_alloc #(.ENTRIES(ENTRIES)) u_alloc (
    .clk(clk), .rst_n(rst_n), .free_i(free_vec),
    .found_o(free_found), .idx_o(free_idx)
  );

  always_comb begin
    match_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) match_idx = IDX_W'(i);
    end
  end

  assign any_match   = |match_vec;
  assign look_match  = miss_vld && any_match;
  assign look_bypass = look_match && byp_vec[match_idx];
  assign look_alloc  = miss_vld && !any_match && free_found;
  assign look_idx    = any_match ? match_idx : free_idx;
  assign do_alloc    = look_alloc && miss_fill;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign alloc_vec[g] = do_alloc && (free_idx == IDX_W'(g));
    assign fill_vec[g]  = miss_vld && miss_fill && match_vec[g];
    assign dn_vec[g]    = hit_vld && !hit_reuse && (hit_idx == IDX_W'(g));
    assign up_vec[g]    = evict_vld && !evict_reuse && (evict_idx == IDX_W'(g));
    assign rel_vec[g]   = evict_vld && (evict_idx == IDX_W'(g));

    pcrt_entry #(.KEY_W(KEY_W), .REF_W(REF_W)) u_ent (
      .clk(clk), .rst_n(rst_n), .key_i(key),
      .alloc_i(alloc_vec[g]), .fill_i(fill_vec[g]),
      .up_i(up_vec[g]), .dn_i(dn_vec[g]), .rel_i(rel_vec[g]),
      .hit_o(match_vec[g]), .free_o(free_vec[g]), .bypass_o(byp_vec[g])
    );
  end

  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec)); // R2
  AST_FULL_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    (free_vec == '0) |-> !look_alloc); // R8
  AST_BYPASS_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    look_bypass |-> look_match); // R4
endmodule

// File: tb/pcrt_table_tb.sv
module pcrt_table_tb;
  localparam int ENT = 8;
  localparam int IW  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic miss_vld = 0, miss_pol = 0, miss_fill = 0;
  logic [15:0] miss_pc = '0;
  logic hit_vld = 0, hit_reuse = 0, evict_vld = 0, evict_reuse = 0;
  logic [IW-1:0] hit_idx = '0, evict_idx = '0;
  logic look_match, look_bypass, look_alloc;
  logic [IW-1:0] look_idx;

  int checks = 0, errors = 0;
  bit done = 0;

  int          m_cnt [ENT];
  int          m_ref [ENT];
  logic [16:0] m_key [ENT];

  always #2 clk = ~clk;

  pcrt_table #(.PC_W(16), .ENTRIES(ENT), .REF_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .miss_vld(miss_vld), .miss_pc(miss_pc),
    .miss_pol(miss_pol), .miss_fill(miss_fill), .hit_vld(hit_vld),
    .hit_idx(hit_idx), .hit_reuse(hit_reuse), .evict_vld(evict_vld),
    .evict_idx(evict_idx), .evict_reuse(evict_reuse),
    .look_match(look_match), .look_bypass(look_bypass),
    .look_alloc(look_alloc), .look_idx(look_idx)
  );

  task automatic step(input bit mv, input logic [15:0] pc, input bit pol,
                      input bit mf, input bit hv, input int hi, input bit hr,
                      input bit ev, input int ei, input bit er, input string tag);
    int fidx, aidx, d;
    bit em, eb, ea;
    int ex_idx;
    @(negedge clk);
    miss_vld = mv; miss_pc = pc; miss_pol = pol; miss_fill = mf;
    hit_vld = hv; hit_idx = hi[IW-1:0]; hit_reuse = hr;
    evict_vld = ev; evict_idx = ei[IW-1:0]; evict_reuse = er;
    #1;
    fidx = -1; aidx = -1;
    for (int i = 0; i < ENT; i++)
      if (m_ref[i] > 0 && m_key[i] == {pol, pc}) fidx = i;
    for (int i = ENT - 1; i >= 0; i--)
      if (m_ref[i] == 0) aidx = i;
    em = mv && fidx >= 0;
    eb = em && m_cnt[fidx] >= 32;
    ea = mv && fidx < 0 && aidx >= 0;
    ex_idx = em ? fidx : aidx;
    checks++;
    if (look_match !== em || look_bypass !== eb || look_alloc !== ea ||
        ((em || ea) && int'(look_idx) != ex_idx)) begin
      errors++;
      $display("FAIL %s: match/bypass/alloc/idx = %b/%b/%b/%0d expected %b/%b/%b/%0d",
               tag, look_match, look_bypass, look_alloc, look_idx, em, eb, ea, ex_idx);
    end
    @(posedge clk);
    if (mv && mf) begin
      if (fidx >= 0) m_ref[fidx]++;
      else if (aidx >= 0) begin
        m_key[aidx] = {pol, pc}; m_cnt[aidx] = 31; m_ref[aidx] = 1;
      end
    end
    for (int i = 0; i < ENT; i++) begin
      d = 0;
      if (hv && !hr && hi == i) d--;
      if (ev && !er && ei == i) d++;
      m_cnt[i] = m_cnt[i] + d;
      if (m_cnt[i] > 63) m_cnt[i] = 63;
      if (m_cnt[i] < 0) m_cnt[i] = 0;
    end
    if (ev) m_ref[ei]--;
  endtask

  task automatic look(input logic [15:0] pc, input bit pol, input bit f, input string tag);
    step(1, pc, pol, f, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic hit(input int i, input bit r, input string tag);
    step(0, 0, 0, 0, 1, i, r, 0, 0, 0, tag);
  endtask
  task automatic evict(input int i, input bit r, input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 1, i, r, tag);
  endtask

  localparam logic [15:0] PCA = 16'h01A0;
  localparam logic [15:0] PCN = 16'h0777;

  initial begin
    for (int i = 0; i < ENT; i++) begin m_cnt[i] = 31; m_ref[i] = 0; m_key[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    look(PCA, 0, 0, "R1");            // empty table, no fill: no change
    look(PCA, 0, 0, "R3");
    look(PCA, 0, 1, "R3");            // allocate idx 0
    look(PCA, 0, 1, "R7");            // match, line count 2
    look(PCA, 1, 1, "R2");            // other policy: idx 1
    look(PCA, 1, 0, "R2");
    evict(0, 0, "R6");                // counter 32
    look(PCA, 0, 0, "R4");
    hit(0, 1, "R5");                  // reused hit: no change
    look(PCA, 0, 0, "R5");
    hit(0, 0, "R5");                  // back to 31
    look(PCA, 0, 0, "R4");
    for (int k = 0; k < 40; k++)      // fill + unreused evict: climb and pin at 63
      step(1, PCA, 0, 1, 0, 0, 0, 1, 0, 0, "R6");
    step(1, PCA, 0, 1, 1, 0, 0, 1, 0, 0, "R9");  // net zero at the top
    for (int k = 0; k < 32; k++) begin
      hit(0, 0, "R6");
      look(PCA, 0, 0, "R6");
    end
    for (int k = 0; k < 40; k++) hit(0, 0, "R5");  // pin at 0
    step(1, PCA, 0, 1, 1, 0, 0, 1, 0, 0, "R9");    // net zero at the bottom
    for (int k = 0; k < 33; k++)
      step(1, PCA, 0, 1, 0, 0, 0, 1, 0, 0, "R5");
    look(PCA, 0, 0, "R4");
    step(1, PCA, 0, 0, 0, 0, 0, 1, 0, 1, "R10");   // last line leaves, still matches
    look(PCA, 0, 0, "R7");            // now free: offered idx 0
    look(PCA, 0, 1, "R7");            // reallocated
    look(PCA, 0, 0, "R7");            // counter back to 31
    for (int k = 2; k < ENT; k++) look(16'h0300 + 16'(k), 0, 1, "R3");
    look(PCN, 0, 1, "R8");            // table full
    look(PCN, 0, 0, "R8");
    evict(3, 1, "R7");
    look(PCN, 1, 1, "R3");            // takes idx 3
    look(PCN, 1, 0, "R3");
    look(PCN, 0, 0, "R2");
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule